// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Status Flags and Branch Decision

This block is the arithmetic and logic stage of a small processor datapath. It takes two W-bit operands and a 4-bit operation select, and combinationally produces a W-bit result. The operation set covers two's-complement addition and subtraction, with and without the stored carry, negation, and the bitwise AND, OR, XOR and complement operations. Two further operations, compare and test, only set the flags and never ask the register file to store a result. A write-request output tells the surrounding datapath whether the result should be stored.

A four-bit status register holds sign (N), zero (Z), signed overflow (V) and carry (C). It loads from the current operation on a clock edge only when the flag-enable input is high. A branch decision output combines a 3-bit condition select with the registered flags. The sequencer can then settle a conditional branch in the cycle after the flag-setting operation.

Top module: `alu_core`

## Requirements
- R1: Op codes 0 (add) and 2 (add with carry) give A+B and A+B+C modulo 2^W, where C is the stored carry flag. The new C is the carry out of the most significant bit.
- R2: Op codes 1 (subtract), 3 (subtract with borrow) and 8 (negate) add the two's complement of the second operand: A+~B+1, A+~B+C and 0+~A+1. The new C is the carry out of that sum, so C=1 means no borrow. Example: 0xF0 minus 0x14 gives 0xDC with N=1, Z=0, V=0, C=1.
- R3: For arithmetic operations, V is set exactly when the carry into the most significant bit differs from the carry out of it.
- R4: N takes the result's most significant bit and Z is set when the result is all zeros. flags_o is packed as {N,Z,V,C}, with N at bit 3 and C at bit 0.
- R5: Op codes 4 (AND), 5 (OR), 6 (XOR) and 7 (complement of A) give the bitwise result. They clear V and keep C at its old value.
- R6: Op code 9 (compare, A minus B) and op code 10 (test, A AND B) set the flags as subtract and AND do, with wr_o low. Every other valid op code raises wr_o.
- R7: After reset all flags are 0. The flags change only on a rising edge where flag_en_i is high and the op code is valid.
- R8: cond_i selects taken_o. 0 gives Z, 1 gives not Z, 2 gives C, 3 gives not C, 4 gives not N, 5 gives N, 6 gives V and 7 gives not V.
- R9: Op codes 11 to 15 are reserved. They drive wr_o low and leave the flags unchanged even with flag_en_i high.
- R10: taken_o depends on the registered flags only. After a flag update it reflects the new flags in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation select |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| flag_en_i | input | 1 | Load the flags at the next edge |
| cond_i | input | 3 | Branch condition select |
| res_o | output | W | Combinational result |
| wr_o | output | 1 | Result should be written back |
| flags_o | output | 4 | Registered flags {N,Z,V,C} |
| taken_o | output | 1 | Branch condition holds |

## Verification
The assertions assume op_i, a_i, b_i, cond_i and flag_en_i are known values that stay steady around each rising edge. The assertions on the adder's internal carries only look at cycles where the operands carry no unknown bits. The stimulus sets every input on the falling edge, from reset onward, so each edge sees settled, defined values. Reserved op codes and deasserted flag enables are mixed in on purpose, because holding the flags is part of the behaviour being checked.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_ADC = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_NOT = 4'd7,
    OP_NEG = 4'd8,
    OP_CMP = 4'd9,
    OP_TST = 4'd10
  } alu_op_e;

  typedef enum logic [2:0] {
    BR_ZERO   = 3'd0,
    BR_NZERO  = 3'd1,
    BR_CARRY  = 3'd2,
    BR_NCARRY = 3'd3,
    BR_PLUS   = 3'd4,
    BR_MINUS  = 3'd5,
    BR_OVF    = 3'd6,
    BR_NOVF   = 3'd7
  } br_cond_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cin_sel_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_INV = 2'd3
  } logic_sel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  typedef struct packed {
    logic       valid;
    logic       writes;
    logic       is_logic;
    logic       zero_a;
    logic       b_from_a;
    logic       inv_b;
    cin_sel_e   cin_sel;
    logic_sel_e lsel;
  } alu_ctrl_t;

  function automatic alu_ctrl_t decode_op(input logic [3:0] op);
    alu_ctrl_t c;
    c = '{valid: 1'b1, writes: 1'b1, is_logic: 1'b0, zero_a: 1'b0,
          b_from_a: 1'b0, inv_b: 1'b0, cin_sel: CIN_ZERO, lsel: LG_AND};
    case (op)
      OP_ADD: ;
      OP_ADC: c.cin_sel = CIN_FLAG;
      OP_SUB: begin c.inv_b = 1'b1; c.cin_sel = CIN_ONE; end
      OP_SBB: begin c.inv_b = 1'b1; c.cin_sel = CIN_FLAG; end
      OP_CMP: begin c.inv_b = 1'b1; c.cin_sel = CIN_ONE; c.writes = 1'b0; end
      OP_NEG: begin
        c.zero_a = 1'b1; c.b_from_a = 1'b1; c.inv_b = 1'b1; c.cin_sel = CIN_ONE;
      end
      OP_AND: c.is_logic = 1'b1;
      OP_OR:  begin c.is_logic = 1'b1; c.lsel = LG_OR;  end
      OP_XOR: begin c.is_logic = 1'b1; c.lsel = LG_XOR; end
      OP_NOT: begin c.is_logic = 1'b1; c.lsel = LG_INV; end
      OP_TST: begin c.is_logic = 1'b1; c.writes = 1'b0; end
      default: begin c.valid = 1'b0; c.writes = 1'b0; c.is_logic = 1'b1; end
    endcase
    return c;
  endfunction

  function automatic logic cond_holds(input logic [2:0] sel, input flags_t f);
    logic raw;
    case (sel[2:1])
      2'd0:    raw = f.z;
      2'd1:    raw = f.c;
      2'd2:    raw = f.n;
      default: raw = f.v;
    endcase
    // even codes test the flag set, except the sign pair whose polarity is swapped
    return (sel[2:1] == 2'd2) ? (raw ^ ~sel[0]) : (raw ^ sel[0]);
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_into_msb,
  output logic         c_out,
  output logic         ovf
);
  localparam int MSB = W - 1;

  logic [W-1:0] low;

  always_comb begin
    low        = {1'b0, opa[MSB-1:0]} + {1'b0, opb[MSB-1:0]} + {{(W-1){1'b0}}, cin};
    c_into_msb = low[MSB];
    sum        = {opa[MSB] ^ opb[MSB] ^ c_into_msb, low[MSB-1:0]};
    c_out      = (opa[MSB] & opb[MSB]) | (c_into_msb & (opa[MSB] ^ opb[MSB]));
    ovf        = c_into_msb ^ c_out;
  end

  always_comb begin
    if (!$isunknown({opa, opb, cin})) begin
      // R3
      signed_ovf_chk: assert (ovf == ((opa[MSB] == opb[MSB]) && (sum[MSB] != opa[MSB])));
      // R1
      wide_sum_chk: assert ({c_out, sum} == ({1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, cin}));
    end
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_sel_e   sel,
  output logic [W-1:0] y
);
  always_comb begin
    case (sel)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      default: y = ~a;
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd,
  input  flags_t nxt,
  output flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= nxt;
  end

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(q));

  // R7
  flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (q == $past(nxt)));

endmodule

// File: rtl/alu_branch.sv
module alu_branch
  import alu_pkg::*;
(
  input  flags_t     f,
  input  logic [2:0] cond,
  output logic       taken
);
  always_comb taken = cond_holds(cond, f);

  always_comb begin
    if (!$isunknown({f, cond})) begin
      // R8
      cond_pair_chk: assert (cond_holds({cond[2:1], ~cond[0]}, f) == !taken);
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         flag_en_i,
  input  logic [2:0]   cond_i,
  output logic [W-1:0] res_o,
  output logic         wr_o,
  output logic [3:0]   flags_o,
  output logic         taken_o
);
  localparam int MSB = W - 1;

  alu_ctrl_t    ctrl;
  flags_t       flags_q;
  flags_t       flags_nxt;
  logic [W-1:0] add_a, add_b, add_sum, lg_y, result;
  logic         add_cin, c_msb, c_out, ovf;
  logic         flag_upd;

  always_comb begin
    ctrl  = decode_op(op_i);
    add_a = ctrl.zero_a ? '0 : a_i;
    add_b = ctrl.b_from_a ? a_i : b_i;
    if (ctrl.inv_b) add_b = ~add_b;
    case (ctrl.cin_sel)
      CIN_ONE:  add_cin = 1'b1;
      CIN_FLAG: add_cin = flags_q.c;
      default:  add_cin = 1'b0;
    endcase
  end

  alu_addsub #(.W(W)) u_add (
    .opa(add_a), .opb(add_b), .cin(add_cin),
    .sum(add_sum), .c_into_msb(c_msb), .c_out(c_out), .ovf(ovf)
  );

  alu_logic #(.W(W)) u_lg (
    .a(a_i), .b(b_i), .sel(ctrl.lsel), .y(lg_y)
  );

  always_comb begin
    result      = ctrl.is_logic ? lg_y : add_sum;
    flags_nxt.n = result[MSB];
    flags_nxt.z = (result == '0);
    flags_nxt.v = ctrl.is_logic ? 1'b0 : ovf;
    flags_nxt.c = ctrl.is_logic ? flags_q.c : c_out;
    flag_upd    = flag_en_i & ctrl.valid;
  end

  alu_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .upd(flag_upd), .nxt(flags_nxt), .q(flags_q)
  );

  alu_branch u_br (
    .f(flags_q), .cond(cond_i), .taken(taken_o)
  );

  assign res_o   = result;
  assign wr_o    = ctrl.writes;
  assign flags_o = flags_q;

  // R5
  logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en_i && (op_i inside {OP_AND, OP_OR, OP_XOR, OP_NOT, OP_TST}))
    |=> (!flags_o[1] && (flags_o[0] == $past(flags_o[0]))));

  // R6
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CMP || op_i == OP_TST) |-> !wr_o);

  // R9
  reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i > 4'd10) |=> $stable(flags_o));

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en_i && op_i <= 4'd10) |=> (flags_o[2] == ($past(res_o) == '0)));

  // R3
  carry_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.is_logic) |-> (ovf == (c_msb != c_out)));

  // R10
  taken_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i == BR_ZERO) |-> (taken_o == flags_o[2]));

endmodule

// File: tb/alu_core_tb.sv
`timescale 1ns/1ps
module alu_core_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   op_i = '0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic         flag_en_i = 1'b0;
  logic [2:0]   cond_i = '0;
  logic [W-1:0] res_o;
  logic         wr_o, taken_o;
  logic [3:0]   flags_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // model flags
  bit mN, mZ, mV, mC;

  always #2.5 clk = ~clk;

  alu_core #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .flag_en_i(flag_en_i), .cond_i(cond_i), .res_o(res_o), .wr_o(wr_o),
    .flags_o(flags_o), .taken_o(taken_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (op=%0d a=%0h b=%0h)",
               req, what, act, exp, op_i, a_i, b_i);
    end
  endtask

  // behavioural reference: integer arithmetic on the stated semantics
  task automatic model(input int op, input int a, input int b,
                       output int res, output bit n, output bit z, output bit v,
                       output bit c, output bit wr, output bit valid);
    int sa, sb, s, sv, bor;
    bit lg;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    s = 0; sv = 0; lg = 0; valid = 1; wr = 1; c = mC;
    case (op)
      0:    begin s = a + b; c = (s > 255); sv = sa + sb; end
      2:    begin s = a + b + int'(mC); c = (s > 255); sv = sa + sb + int'(mC); end
      1, 9: begin s = a - b; c = (a >= b); sv = sa - sb; wr = (op == 1); end
      3:    begin bor = mC ? 0 : 1; s = a - b - bor; c = (a >= b + bor); sv = sa - sb - bor; end
      8:    begin s = -a; c = (a == 0); sv = -sa; end
      4, 10:begin s = a & b; lg = 1; wr = (op == 4); end
      5:    begin s = a | b; lg = 1; end
      6:    begin s = a ^ b; lg = 1; end
      7:    begin s = 255 - a; lg = 1; end
      default: begin valid = 0; wr = 0; end
    endcase
    res = s & 255;
    n = res[7];
    z = (res == 0);
    v = lg ? 0 : (sv > 127 || sv < -128);
  endtask

  function automatic bit model_taken(input int cnd);
    case (cnd)
      0: return mZ;   1: return !mZ;
      2: return mC;   3: return !mC;
      4: return !mN;  5: return mN;
      6: return mV;   default: return !mV;
    endcase
  endfunction

  function automatic string op_req(input int op);
    case (op)
      0, 2:    return "R1";
      1, 3, 8: return "R2";
      4, 5, 6, 7: return "R5";
      9, 10:   return "R6";
      default: return "R9";
    endcase
  endfunction

  // one cycle: drive at falling edge, compare, advance the model at the rising edge
  task automatic step(input int op, input int a, input int b, input bit en, input int cnd);
    int r; bit n, z, v, c, wr, valid;
    @(negedge clk);
    op_i = 4'(op); a_i = 8'(a); b_i = 8'(b); flag_en_i = en; cond_i = 3'(cnd);
    #1;
    model(op, a, b, r, n, z, v, c, wr, valid);
    check(op_req(op), "write request", int'(wr_o), int'(wr));
    if (wr) check(op_req(op), "result", int'(res_o), r);
    check("R4", "N,Z flags", int'(flags_o[3:2]), int'({mN, mZ}));
    check("R3", "V flag", int'(flags_o[1]), int'(mV));
    check("R7", "C flag", int'(flags_o[0]), int'(mC));
    check("R8", "taken", int'(taken_o), int'(model_taken(cnd)));
    @(posedge clk);
    if (en && valid) begin mN = n; mZ = z; mV = v; mC = c; end
  endtask

  initial begin
    mN = 0; mZ = 0; mV = 0; mC = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7", "flags after reset", int'(flags_o), 0);
    rst_n = 1'b1;

    // R2 worked example, then R10 taken follows the new flags next cycle
    step(1, 8'hF0, 8'h14, 1, 0);
    @(negedge clk); #1;
    check("R2", "example flags NZVC", int'(flags_o), 4'b1001);
    cond_i = 3'd5; #0.1;
    check("R10", "minus taken after update", int'(taken_o), 1);
    // R1 carries and overflow
    step(0, 8'h7F, 8'h01, 1, 6);
    step(0, 8'hFF, 8'h01, 1, 0);
    step(2, 8'h10, 8'h20, 1, 2);
    step(2, 8'h7F, 8'h00, 1, 6);
    // R2 borrow, negate corners
    step(1, 8'h00, 8'h01, 1, 3);
    step(3, 8'h05, 8'h05, 1, 1);
    step(3, 8'h80, 8'h01, 1, 6);
    step(8, 8'h80, 8'h00, 1, 6);
    step(8, 8'h00, 8'h00, 1, 2);
    // R6 compare and test
    step(9, 8'h33, 8'h33, 1, 0);
    step(10, 8'hF0, 8'h0F, 1, 0);
    // R5 logic keeps C, clears V
    step(0, 8'h80, 8'h80, 1, 2);
    step(7, 8'h00, 8'h00, 1, 2);
    // R7 no enable, R9 reserved with enable
    step(1, 8'h00, 8'h00, 0, 0);
    step(12, 8'h00, 8'h00, 1, 0);
    step(15, 8'hAA, 8'h55, 1, 7);
    for (int k = 0; k < 8; k++) step(k % 11, 8'h40 + k, 8'h3F, k[0], k);

    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 255),
           ($urandom_range(0, 3) != 0), $urandom_range(0, 7));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule